// File: doc/BRIEF.md
# Memory-Module Configuration EEPROM Slave

This block is a two-wire serial slave that models the small configuration memory found on a plug-in memory module. A host reads it at boot to learn the module's parameters. The storage is a 256-byte array, and the lower half of it carries the standardized parameters. A preload port fills the array. The bus side supports several transfers: byte writes, random reads (a pointer write, then a repeated START and a read), current-address reads, and sequential reads. All of them go through one internal 8-bit word pointer that wraps from 255 to 0.

Up to eight modules can share one bus. Three strap inputs give each module its own address. The array answers at 0x50 OR strap. A second window at 0x30 OR strap is acknowledged only while the write-protect input is low. It behaves as a stub: data bytes are acknowledged but leave the array alone, and reads return all ones. An optional stub at 0x18 OR strap stands in for a temperature sensor. It acknowledges writes and returns a fixed byte on every read.

The bus lines are oversampled in the system clock domain. The block drives SDA only by pulling it low. Timeouts, packet error checking, clock stretching and write-cycle delays are not modelled.

Top module: `modcfg_eeprom`

## Requirements
- R1: The array window answers the 7-bit address {1010, strap} with ACK. An address that matches no active window is NACKed, and the slave then stays off the bus until the next START.
- R2: The window {0110, strap} is ACKed only while wpIn is low, and its data bytes are ACKed too. Writes through it leave the array unchanged. While wpIn is high, its address is NACKed.
- R3: With SENSOR_EN set, the window {0011, strap} is ACKed. Every byte read from it equals SENSOR_WORD (default 8'h3C), and bytes written to it are ACKed and ignored.
- R4: In a write to the array window, the first data byte is loaded into the word pointer. A later read returns the array byte at that pointer.
- R5: In a write, each data byte after the first is stored at the pointer and ACKed. The pointer then increments, wrapping from 255 to 0.
- R6: While wpIn is high, data bytes for the array (after the pointer byte) are NACKed and the array is unchanged. The pointer byte is still ACKed, and reads still work.
- R7: A read with no pointer write starts at the current pointer. Each transmitted array byte advances the pointer, wrapping from 255 to 0. The read ends when the master NACKs.
- R8: SDA is only ever pulled low. The pull changes only while SCL is low.
- R9: Reset clears the pointer to 0, returns the bus logic to idle, and releases SDA.
- R10: A START begins a new address phase from any state (a repeated START). A STOP returns the slave to idle with SDA released.
- R11: While loadEn is high, the preload port writes loadData into the array at loadAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap | input | 3 | Slot strap, the low three address bits |
| wpIn | input | 1 | Write protect, active high |
| loadEn | input | 1 | Preload write enable |
| loadAddr | input | 8 | Preload array address |
| loadData | input | 8 | Preload data byte |
| sdaPullLow | output | 1 | When high, the open-drain driver pulls SDA low |

## Verification
The bench targets the places where the pointer crosses 255. One sequential read and one multi-byte write both wrap through it. A design that saturated the pointer, or failed to carry it between transactions, would return or overwrite the wrong bytes. Write protect is exercised in both directions. The pointer byte must still be ACKed so that a random read works, and the data byte must be NACKed and leave storage intact. A design that blocked the whole write would break reads, and one that only dropped the store would give a misleading ACK. The protect-command window is probed with the protect input at both levels. A read started by a repeated START, a STOP that follows the pointer byte, and a foreign slot address check that the slave never holds SDA after the point where it should let go.

// File: rtl/modcfg_pkg.sv
package modcfg_pkg;

  localparam int WORD_W    = 8;
  localparam int PTR_W     = 8;
  localparam int MEM_DEPTH = 1 << PTR_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } busState_e;

  typedef enum logic [1:0] {
    TGT_MEM,
    TGT_PROT,
    TGT_SENS
  } target_e;

  typedef enum logic [1:0] {
    TX_MEM,
    TX_IDLE,
    TX_SENS
  } txSrc_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic   shiftIn;
    logic   setPtr;
    logic   writeMem;
    logic   incPtr;
    logic   loadTx;
    logic   shiftTx;
    txSrc_e txSrc;
  } dpStrobe_t;

endpackage

// File: rtl/modcfg_dp.sv
module modcfg_dp
  import modcfg_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] SENSOR_WORD = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  input  logic              loadEn,
  input  logic [PTR_W-1:0]  loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  dpStrobe_t         strobe,
  output logic              sclLvl,
  output logic              sdaLvl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic [WORD_W-1:0] rxByte,
  output logic              txBit
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic              sclOld;
  logic              sdaOld;

  logic [WORD_W-1:0] mem [MEM_DEPTH];
  logic [PTR_W-1:0]  wordPtr;
  logic [WORD_W-1:0] txShift;

  // Line synchronizers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclLvl  = sclPipe[SYNC_STAGES-1];
  assign sclOld  = sclPipe[SYNC_STAGES];
  assign sdaLvl  = sdaPipe[SYNC_STAGES-1];
  assign sdaOld  = sdaPipe[SYNC_STAGES];

  assign sclRise = sclLvl & ~sclOld;
  assign sclFall = ~sclLvl & sclOld;
  assign startEv = sclLvl & sclOld & sdaOld & ~sdaLvl;
  assign stopEv  = sclLvl & sclOld & ~sdaOld & sdaLvl;

  // Receive shifter
  always_ff @(posedge clk) begin
    if (!rstN)              rxByte <= '0;
    else if (strobe.shiftIn) rxByte <= {rxByte[WORD_W-2:0], sdaLvl};
  end

  // Storage array: preload port has priority over bus writes
  always_ff @(posedge clk) begin
    if (loadEn)               mem[loadAddr] <= loadData;
    else if (strobe.writeMem) mem[wordPtr]  <= rxByte;
  end

  // Word pointer
  always_ff @(posedge clk) begin
    if (!rstN)               wordPtr <= '0;
    else if (strobe.setPtr)  wordPtr <= rxByte[PTR_W-1:0];
    else if (strobe.incPtr)  wordPtr <= wordPtr + 1'b1;
  end

  // Transmit shifter, idles at all ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strobe.loadTx) begin
      case (strobe.txSrc)
        TX_MEM:  txShift <= mem[wordPtr];
        TX_SENS: txShift <= SENSOR_WORD;
        default: txShift <= '1;
      endcase
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[WORD_W-2:0], 1'b1};
    end
  end

  assign txBit = txShift[WORD_W-1];

  // R5/R7: pointer steps by exactly one, wrapping at the top
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incPtr && !strobe.setPtr) |=> wordPtr == $past(wordPtr) + 1'b1);

  // R6: no store reaches the array while protected
  a_r6_wp_blocks_store: assert property (@(posedge clk) disable iff (!rstN)
    wpIn |-> !strobe.writeMem);

endmodule

// File: rtl/modcfg_ctrl.sv
module modcfg_ctrl
  import modcfg_pkg::*;
#(
  parameter bit         SENSOR_EN   = 1'b1,
  parameter logic [3:0] MEM_PREFIX  = 4'b1010,
  parameter logic [3:0] PROT_PREFIX = 4'b0110,
  parameter logic [3:0] SENS_PREFIX = 4'b0011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        strap,
  input  logic              wpIn,
  input  logic              sclLvl,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic [WORD_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strobe,
  output logic              sdaDrive
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [3:0] LAST_TX_BIT   = 4'd7;

  busState_e state, stateNxt;
  target_e   target, targetNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic      isRead, isReadNxt;
  logic      firstByte, firstByteNxt;
  logic      ackDrive, ackDriveNxt;
  logic      masterAck, masterAckNxt;

  logic [6:0] devAddr;
  logic       hitMem;
  logic       hitProt;
  logic       hitSens;
  txSrc_e     txSel;

  assign devAddr = rxByte[WORD_W-1:1];
  assign hitMem  = (devAddr == {MEM_PREFIX, strap});
  assign hitProt = !wpIn && (devAddr == {PROT_PREFIX, strap});

  generate
    if (SENSOR_EN) begin : g_sensor
      assign hitSens = (devAddr == {SENS_PREFIX, strap});
    end else begin : g_no_sensor
      assign hitSens = 1'b0;
    end
  endgenerate

  always_comb begin
    case (target)
      TGT_MEM:  txSel = TX_MEM;
      TGT_SENS: txSel = TX_SENS;
      default:  txSel = TX_IDLE;
    endcase
  end

  always_comb begin
    stateNxt     = state;
    targetNxt    = target;
    bitCntNxt    = bitCnt;
    isReadNxt    = isRead;
    firstByteNxt = firstByte;
    ackDriveNxt  = ackDrive;
    masterAckNxt = masterAck;
    strobe       = '0;
    strobe.txSrc = txSel;

    if (stopEv) begin
      stateNxt    = ST_IDLE;
      ackDriveNxt = 1'b0;
    end else if (startEv) begin
      stateNxt    = ST_ADDR;
      bitCntNxt   = '0;
      ackDriveNxt = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            bitCntNxt      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
            if (hitMem || hitProt || hitSens) begin
              stateNxt     = ST_ADDR_ACK;
              ackDriveNxt  = 1'b1;
              isReadNxt    = rxByte[0];
              firstByteNxt = 1'b1;
              if (hitMem)       targetNxt = TGT_MEM;
              else if (hitProt) targetNxt = TGT_PROT;
              else              targetNxt = TGT_SENS;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDriveNxt = 1'b0;
            bitCntNxt   = '0;
            if (isRead) begin
              strobe.loadTx = 1'b1;
              stateNxt      = ST_RD_BYTE;
            end else begin
              stateNxt = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            bitCntNxt      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
            if (target != TGT_MEM) begin
              stateNxt    = ST_WR_ACK;
              ackDriveNxt = 1'b1;
            end else if (firstByte) begin
              strobe.setPtr = 1'b1;
              firstByteNxt  = 1'b0;
              stateNxt      = ST_WR_ACK;
              ackDriveNxt   = 1'b1;
            end else if (wpIn) begin
              stateNxt = ST_IDLE;
            end else begin
              strobe.writeMem = 1'b1;
              strobe.incPtr   = 1'b1;
              stateNxt        = ST_WR_ACK;
              ackDriveNxt     = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ackDriveNxt = 1'b0;
            bitCntNxt   = '0;
            stateNxt    = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX_BIT) begin
              stateNxt      = ST_RD_ACK;
              strobe.incPtr = (target == TGT_MEM);
            end else begin
              strobe.shiftTx = 1'b1;
              bitCntNxt      = bitCnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            masterAckNxt = !sdaLvl;
          end else if (sclFall) begin
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              bitCntNxt     = '0;
              stateNxt      = ST_RD_BYTE;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      target    <= TGT_MEM;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      ackDrive  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      target    <= targetNxt;
      bitCnt    <= bitCntNxt;
      isRead    <= isReadNxt;
      firstByte <= firstByteNxt;
      ackDrive  <= ackDriveNxt;
      masterAck <= masterAckNxt;
    end
  end

  assign sdaDrive = ackDrive | ((state == ST_RD_BYTE) & ~txBit);

  // R8: the pull never moves while the sampled clock line stays high
  a_r8_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaDrive));

  // R10: a STOP leaves the slave idle and off the bus
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == ST_IDLE && !sdaDrive));

  // R1: an unmatched address is never acknowledged
  a_r1_foreign_nack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && bitCnt == BITS_PER_BYTE &&
     !(hitMem || hitProt || hitSens)) |=> (!sdaDrive && state == ST_IDLE));

  // R2: the protect-command window is never selected under write protect
  a_r2_prot_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wpIn && state == ST_ADDR_ACK) |-> target != TGT_PROT);

endmodule

// File: rtl/modcfg_eeprom.sv
module modcfg_eeprom
  import modcfg_pkg::*;
#(
  parameter bit          SENSOR_EN   = 1'b1,
  parameter logic [7:0]  SENSOR_WORD = 8'h3C,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       wpIn,
  input  logic       loadEn,
  input  logic [7:0] loadAddr,
  input  logic [7:0] loadData,
  output logic       sdaPullLow
);

  dpStrobe_t         strobe;
  logic              sclLvl;
  logic              sdaLvl;
  logic              sclRise;
  logic              sclFall;
  logic              startEv;
  logic              stopEv;
  logic [WORD_W-1:0] rxByte;
  logic              txBit;

  modcfg_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .SENSOR_WORD(SENSOR_WORD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .wpIn     (wpIn),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .strobe   (strobe),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startEv  (startEv),
    .stopEv   (stopEv),
    .rxByte   (rxByte),
    .txBit    (txBit)
  );

  modcfg_ctrl #(
    .SENSOR_EN(SENSOR_EN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strap    (strap),
    .wpIn     (wpIn),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startEv  (startEv),
    .stopEv   (stopEv),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .strobe   (strobe),
    .sdaDrive (sdaPullLow)
  );

endmodule

// File: tb/tb_modcfg_eeprom.sv
module tb_modcfg_eeprom;

  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] MEM_W  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] MEM_R  = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] PROT_W = {4'b0110, STRAP, 1'b0};
  localparam logic [7:0] SENS_W = {4'b0011, STRAP, 1'b0};
  localparam logic [7:0] SENS_R = {4'b0011, STRAP, 1'b1};
  localparam logic [7:0] FOREIGN_W = {4'b1010, 3'b100, 1'b0};
  localparam logic [7:0] SENSOR_VAL = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wpIn = 1'b0;
  logic loadEn = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic sdaPullLow;
  logic sdaLine;

  int checks = 0;
  int fails = 0;
  int r8Viol = 0;
  logic prevPull = 1'b0;
  bit finished = 1'b0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  modcfg_eeprom dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .strap      (STRAP),
    .wpIn       (wpIn),
    .loadEn     (loadEn),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .sdaPullLow (sdaPullLow)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R8 monitor: the pull may change only while the clock line is low
  always begin
    @(negedge clk);
    #1;
    if (rstN && sclM && (sdaPullLow != prevPull)) r8Viol++;
    prevPull = sdaPullLow;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic wbit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic rbit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(~giveAck);
  endtask

  // Pointer write followed by repeated START into a read, n bytes
  task automatic randomRead(input string req, input logic [7:0] ptr, input int n);
    logic ack;
    logic [7:0] v;
    startC();
    sendByte(MEM_W, ack); chk(req, "ptr-write addr ack", ack, 1);
    sendByte(ptr, ack);   chk(req, "ptr byte ack", ack, 1);
    startC();
    sendByte(MEM_R, ack); chk("R10", "repeated-start read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(v, i != n - 1);
      chk(req, "read data", v, model[8'(ptr + i)]);
    end
    stopC();
  endtask

  task automatic t_reset_state();
    logic ack;
    logic [7:0] v;
    chk("R9", "no pull during reset", sdaPullLow, 0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 256; i++) begin
      loadEn = 1'b1; loadAddr = 8'(i); loadData = pat(i);
      model[i] = pat(i);
      @(negedge clk);
    end
    loadEn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", "no pull after reset", sdaPullLow, 0);
    startC();
    sendByte(MEM_R, ack); chk("R1", "array window read ack", ack, 1);
    recvByte(v, 1'b0);    chk("R9", "pointer zero after reset", v, model[0]);
    stopC();
  endtask

  task automatic t_random_seq_read();
    randomRead("R4", 8'h40, 3);
  endtask

  task automatic t_current_read();
    logic ack;
    logic [7:0] v;
    startC();
    sendByte(MEM_R, ack); chk("R7", "current read ack", ack, 1);
    recvByte(v, 1'b0);    chk("R7", "current read continues at pointer", v, model[8'h43]);
    stopC();
  endtask

  task automatic t_wrap_read();
    randomRead("R7", 8'hFE, 3);
  endtask

  task automatic t_write_wrap();
    logic ack;
    startC();
    sendByte(MEM_W, ack); chk("R5", "write addr ack", ack, 1);
    sendByte(8'hFE, ack); chk("R4", "pointer byte ack", ack, 1);
    sendByte(8'h11, ack); chk("R5", "data 0 ack", ack, 1);
    sendByte(8'h22, ack); chk("R5", "data 1 ack", ack, 1);
    sendByte(8'h33, ack); chk("R5", "data 2 ack after wrap", ack, 1);
    stopC();
    model[8'hFE] = 8'h11; model[8'hFF] = 8'h22; model[8'h00] = 8'h33;
    randomRead("R5", 8'hFE, 3);
  endtask

  task automatic t_write_protect();
    logic ack;
    wpIn = 1'b1;
    startC();
    sendByte(MEM_W, ack); chk("R6", "addr ack under wp", ack, 1);
    sendByte(8'h10, ack); chk("R6", "pointer byte ack under wp", ack, 1);
    sendByte(8'h99, ack); chk("R6", "data nack under wp", ack, 0);
    stopC();
    chk("R6", "no pull after nack", sdaPullLow, 0);
    randomRead("R6", 8'h10, 1);
    wpIn = 1'b0;
  endtask

  task automatic t_prot_window();
    logic ack;
    startC();
    sendByte(PROT_W, ack); chk("R2", "protect window ack wp low", ack, 1);
    sendByte(8'h10, ack);  chk("R2", "protect data ack 0", ack, 1);
    sendByte(8'h77, ack);  chk("R2", "protect data ack 1", ack, 1);
    stopC();
    randomRead("R2", 8'h10, 2);
    wpIn = 1'b1;
    startC();
    sendByte(PROT_W, ack); chk("R2", "protect window nack wp high", ack, 0);
    stopC();
    wpIn = 1'b0;
  endtask

  task automatic t_sensor();
    logic ack;
    logic [7:0] v;
    startC();
    sendByte(SENS_R, ack); chk("R3", "sensor read ack", ack, 1);
    recvByte(v, 1'b1);     chk("R3", "sensor byte 0", v, SENSOR_VAL);
    recvByte(v, 1'b0);     chk("R3", "sensor byte 1", v, SENSOR_VAL);
    stopC();
    startC();
    sendByte(SENS_W, ack); chk("R3", "sensor write addr ack", ack, 1);
    sendByte(8'h05, ack);  chk("R3", "sensor write data ack", ack, 1);
    stopC();
  endtask

  task automatic t_foreign();
    logic ack;
    logic [7:0] v;
    startC();
    sendByte(FOREIGN_W, ack); chk("R1", "foreign slot nack", ack, 0);
    recvByte(v, 1'b0);        chk("R1", "silent until next start", v, 8'hFF);
    stopC();
    chk("R1", "no pull after foreign", sdaPullLow, 0);
  endtask

  task automatic t_load_port();
    loadEn = 1'b1; loadAddr = 8'h80; loadData = 8'hC3;
    @(negedge clk);
    loadEn = 1'b0;
    model[8'h80] = 8'hC3;
    randomRead("R11", 8'h80, 1);
  endtask

  task automatic t_stop_after_ptr();
    logic ack;
    logic [7:0] v;
    startC();
    sendByte(MEM_W, ack); chk("R10", "addr ack", ack, 1);
    sendByte(8'h20, ack); chk("R4", "pointer byte ack", ack, 1);
    stopC();
    chk("R10", "idle after stop", sdaPullLow, 0);
    startC();
    sendByte(MEM_R, ack); chk("R4", "read ack", ack, 1);
    recvByte(v, 1'b0);    chk("R4", "read at set pointer", v, model[8'h20]);
    stopC();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset_state();
    t_random_seq_read();
    t_current_read();
    t_wrap_read();
    t_write_wrap();
    t_write_protect();
    t_prot_window();
    t_sensor();
    t_foreign();
    t_load_port();
    t_stop_after_ptr();
    chk("R8", "pull changes while SCL high", r8Viol, 0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule